// File: doc/BRIEF.md
# Pipelined Direct-Form Low-Pass FIR Filter

This block is a single-rate FIR filter. Each accepted signed 16-bit sample passes through a chain of multiply-add stages. Every stage ends in a register, so the longest path from one register to the next is one multiplier followed by one adder. The cost of those registers is a sample delay line with two registers per tap, so that each stage lines up its partial sum with a sample of the right age. The tap count and the signed 24-bit coefficients are parameters. The coefficients are passed as one packed vector, with tap `t` in bits `[t*24 +: 24]`.

A sample-valid strobe acts as a clock enable for the whole pipeline. When it is low, nothing moves and the result holds. Every product is 40 bits wide, and every partial sum is carried in a 40-bit two's-complement accumulator that wraps on overflow. The output is the final sum shifted right arithmetically by 24 bits, which gives bits [39:24]. An output-valid flag turns on once as many samples as there are taps have been accepted.

Top module: `fir_pipelined`

## Requirements
- R1: While reset is high, and in the cycle after it falls, `yOut` is 0 and `outValid` is 0.
- R2: Let N be the tap count and x(m) the m-th sample accepted since reset (x(m)=0 for m<0). After the clock edge that accepts sample k, `yOut` equals bits [39:24] of the 40-bit sum over i=0..N-1 of c(i)*x(k-N+1-i).
- R3: The output scaling is an arithmetic shift that rounds toward minus infinity. A small negative sum gives -1, not 0.
- R4: The 40-bit accumulator wraps modulo 2^40 on overflow, and the output is taken from the wrapped sum.
- R5: In a cycle where `inValid` is low, `xIn` is ignored, `yOut` keeps its previous value and `outValid` is low in the following cycle.
- R6: `outValid` is 0 until the edge that accepts the N-th sample after reset. From then on it equals `inValid` from the previous cycle.
- R7: A reset in the middle of a stream clears all history, so later results behave as if every earlier sample had been zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Sample strobe; advances the pipeline |
| xIn | input | 16 | Signed input sample |
| outValid | output | 1 | A new result was produced on the last edge, with the pipeline filled |
| yOut | output | 16 | Signed filtered result |

## Verification
An impulse shows each coefficient on its own, in order, so a wrong tap order, a wrong delay-line index or a wrong latency shows up as a result at the wrong cycle. Long runs of full-scale positive and negative samples push the sum past the 40-bit range and test the wrap. Small negative inputs tell an arithmetic shift apart from a logical or truncating one. Random samples with a random strobe that often goes low test the stall path, that `xIn` is ignored during a stall and the fill count of the valid flag. A reset in mid-stream tests that all history is cleared.

// File: rtl/fir_pipelined_pkg.sv
package fir_pipelined_pkg;

  // Strobes from the control unit to the datapath.
  typedef struct packed {
    logic advance;   // shift the delay line and update every accumulator stage
    logic clear;     // zero every pipeline register
  } dpStrobe_t;

endpackage

// File: rtl/fir_pipelined_mac.sv
module fir_pipelined_mac #(
  parameter int SAMPLE_W = 16,
  parameter int COEF_W   = 24,
  parameter int ACC_W    = 40,
  parameter logic signed [COEF_W-1:0] COEF = '0
) (
  input  logic                              clk,
  input  fir_pipelined_pkg::dpStrobe_t      strb,
  input  logic signed [ACC_W-1:0]           accIn,
  input  logic signed [SAMPLE_W-1:0]        sampleIn,
  output logic signed [ACC_W-1:0]           accOut
);

  logic signed [ACC_W-1:0] product;
  logic signed [ACC_W-1:0] sum;

  // Both operands are sign-extended to ACC_W. The product is exact when
  // ACC_W >= SAMPLE_W + COEF_W. The sum wraps modulo 2^ACC_W.
  always_comb begin
    product = ACC_W'(sampleIn) * ACC_W'(COEF);
    sum     = accIn + product;
  end

  always_ff @(posedge clk) begin
    if (strb.clear) begin
      accOut <= '0;
    end else if (strb.advance) begin
      accOut <= sum;
    end
  end

endmodule

// File: rtl/fir_pipelined_ctrl.sv
module fir_pipelined_ctrl #(
  parameter int NUM_TAPS = 102
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          inValid,
  output fir_pipelined_pkg::dpStrobe_t  strb,
  output logic                          outValid
);

  localparam int CNT_W = (NUM_TAPS > 2) ? $clog2(NUM_TAPS) : 1;
  localparam logic [CNT_W-1:0] LAST_FILL = CNT_W'(NUM_TAPS - 1);

  logic [CNT_W-1:0] fillCnt;
  logic             filled;
  logic             lastFill;

  always_comb begin
    strb.clear   = rst;
    strb.advance = inValid && !rst;
    lastFill     = (fillCnt == LAST_FILL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fillCnt  <= '0;
      filled   <= 1'b0;
      outValid <= 1'b0;
    end else begin
      outValid <= strb.advance && (filled || lastFill);
      if (strb.advance && !filled) begin
        if (lastFill) begin
          filled <= 1'b1;
        end else begin
          fillCnt <= fillCnt + 1'b1;
        end
      end
    end
  end

  // R6: the fill counter never goes past the last tap index.
  a_r6_fill_bound: assert property (@(posedge clk) disable iff (rst)
    fillCnt <= LAST_FILL);

  // R6: a valid result always follows a cycle in which a sample was accepted.
  a_r6_valid_after_accept: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(inValid));

  // R6: the pipeline is marked full only on an edge that accepts a sample.
  a_r6_fill_on_accept: assert property (@(posedge clk) disable iff (rst)
    $rose(filled) |-> $past(inValid));

  // R5: a stalled cycle never gives a valid result.
  a_r5_no_valid_on_stall: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

endmodule

// File: rtl/fir_pipelined_dp.sv
module fir_pipelined_dp #(
  parameter int NUM_TAPS   = 102,
  parameter int SAMPLE_W   = 16,
  parameter int COEF_W     = 24,
  parameter int ACC_W      = 40,
  parameter int FRAC_SHIFT = 24,
  parameter logic [NUM_TAPS*COEF_W-1:0] COEFS = '0
) (
  input  logic                          clk,
  input  fir_pipelined_pkg::dpStrobe_t  strb,
  input  logic signed [SAMPLE_W-1:0]    xIn,
  output logic signed [SAMPLE_W-1:0]    yOut
);

  // Two delay registers per tap. Stage t reads element 2t-1, so the
  // last element read is 2*NUM_TAPS-3.
  localparam int DLY_LEN = 2 * NUM_TAPS - 2;

  logic signed [SAMPLE_W-1:0] dly [DLY_LEN];
  logic signed [ACC_W-1:0]    accChain [NUM_TAPS];
  logic signed [ACC_W-1:0]    accLast;

  always_ff @(posedge clk) begin
    if (strb.clear) begin
      for (int k = 0; k < DLY_LEN; k++) dly[k] <= '0;
    end else if (strb.advance) begin
      dly[0] <= xIn;
      for (int k = 1; k < DLY_LEN; k++) dly[k] <= dly[k-1];
    end
  end

  for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
    logic signed [SAMPLE_W-1:0] tapSample;
    logic signed [ACC_W-1:0]    tapAccIn;

    if (t == 0) begin : g_head
      assign tapSample = xIn;
      assign tapAccIn  = '0;
    end else begin : g_body
      assign tapSample = dly[2*t-1];
      assign tapAccIn  = accChain[t-1];
    end

    fir_pipelined_mac #(
      .SAMPLE_W (SAMPLE_W),
      .COEF_W   (COEF_W),
      .ACC_W    (ACC_W),
      .COEF     (COEFS[t*COEF_W +: COEF_W])
    ) u_mac (
      .clk      (clk),
      .strb     (strb),
      .accIn    (tapAccIn),
      .sampleIn (tapSample),
      .accOut   (accChain[t])
    );
  end

  assign accLast = accChain[NUM_TAPS-1];
  // Arithmetic shift by FRAC_SHIFT, keeping SAMPLE_W bits.
  assign yOut    = accLast[FRAC_SHIFT +: SAMPLE_W];

  // R5: with no advance and no clear, the whole final sum is held.
  a_r5_hold_sum: assert property (@(posedge clk) disable iff (strb.clear)
    !strb.advance |=> $stable(accLast));

  // R5: the tail of the delay line is held during a stall.
  a_r5_hold_tail: assert property (@(posedge clk) disable iff (strb.clear)
    !strb.advance |=> $stable(dly[DLY_LEN-1]));

endmodule

// File: rtl/fir_pipelined.sv
module fir_pipelined #(
  parameter int NUM_TAPS   = 102,
  parameter int SAMPLE_W   = 16,
  parameter int COEF_W     = 24,
  parameter int ACC_W      = 40,
  parameter int FRAC_SHIFT = 24,
  parameter logic [NUM_TAPS*COEF_W-1:0] COEFS = {NUM_TAPS{COEF_W'(164482)}}
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       inValid,
  input  logic signed [SAMPLE_W-1:0] xIn,
  output logic                       outValid,
  output logic signed [SAMPLE_W-1:0] yOut
);

  fir_pipelined_pkg::dpStrobe_t strb;

  fir_pipelined_ctrl #(
    .NUM_TAPS (NUM_TAPS)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strb     (strb),
    .outValid (outValid)
  );

  fir_pipelined_dp #(
    .NUM_TAPS   (NUM_TAPS),
    .SAMPLE_W   (SAMPLE_W),
    .COEF_W     (COEF_W),
    .ACC_W      (ACC_W),
    .FRAC_SHIFT (FRAC_SHIFT),
    .COEFS      (COEFS)
  ) u_dp (
    .clk  (clk),
    .strb (strb),
    .xIn  (xIn),
    .yOut (yOut)
  );

endmodule

// File: tb/fir_pipelined_tb.sv
`timescale 1ns/1ps
module fir_pipelined_tb;

  localparam int N = 12;
  localparam int HIST = 4096;
  localparam int TB_C [N] = '{8388607, -8388608, 4194304, 1048576, -1, 0,
                              77777, -3000000, 8000000, 8388607, 16, -5};

  function automatic logic [N*24-1:0] packCoefs();
    logic [N*24-1:0] v;
    v = '0;
    for (int i = 0; i < N; i++) v[i*24 +: 24] = 24'(TB_C[i]);
    return v;
  endfunction

  localparam logic [N*24-1:0] TB_COEFS = packCoefs();

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic signed [15:0] xIn = '0;
  logic outValid;
  logic signed [15:0] yOut;

  always #2.5 clk = ~clk;

  fir_pipelined #(
    .NUM_TAPS (N),
    .COEFS    (TB_COEFS)
  ) u_dut (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .xIn      (xIn),
    .outValid (outValid),
    .yOut     (yOut)
  );

  int checks = 0;
  int fails = 0;
  int nAcc = 0;
  logic signed [15:0] hist [HIST];
  logic signed [15:0] lastY = '0;
  bit done = 1'b0;

  // Bit-exact reference for output index m (zero history before 0).
  function automatic logic signed [15:0] refY(input int m);
    logic signed [39:0] acc;
    logic signed [39:0] p;
    acc = '0;
    for (int i = 0; i < N; i++) begin
      if (m - i >= 0) begin
        p = $signed(hist[m-i]) * $signed(TB_C[i]);
        acc = acc + p;
      end
    end
    return acc[39:24];
  endfunction

  task automatic check(input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Called at a negedge: drive, clock, then check at the next negedge.
  task automatic step(input logic v, input logic signed [15:0] x, input string tag);
    logic signed [15:0] expY;
    inValid = v;
    xIn = x;
    @(posedge clk);
    if (v) begin
      hist[nAcc] = x;
      nAcc++;
    end
    @(negedge clk);
    if (v) begin
      expY = refY(nAcc - N);
      check(tag, "yOut", int'(yOut), int'(expY));
      check(tag, "outValid", int'(outValid), (nAcc >= N) ? 1 : 0);
      lastY = expY;
    end else begin
      check(tag, "yOut held", int'(yOut), int'(lastY));
      check(tag, "outValid on stall", int'(outValid), 0);
    end
  endtask

  task automatic doReset(input string tag);
    rst = 1'b1;
    inValid = 1'b1;
    xIn = 16'sd12345;
    @(posedge clk);
    @(negedge clk);
    check(tag, "yOut in reset", int'(yOut), 0);
    check(tag, "outValid in reset", int'(outValid), 0);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    inValid = 1'b0;
    nAcc = 0;
    lastY = '0;
    @(posedge clk);
    @(negedge clk);
    check(tag, "yOut after reset", int'(yOut), 0);
    check(tag, "outValid after reset", int'(outValid), 0);
  endtask

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    @(negedge clk);
    // R1: reset state
    doReset("R1");

    // R6: impulse, outValid must stay low until N samples are accepted
    step(1'b1, 16'sd16384, "R6");
    for (int i = 1; i < N; i++) step(1'b1, 16'sd0, "R6");
    // R2: rest of the impulse response, coefficient by coefficient
    for (int i = 0; i < N + 3; i++) step(1'b1, 16'sd0, "R2");

    // R5: stalls with junk on xIn in between accepted samples
    for (int i = 0; i < 40; i++) begin
      step(1'b1, 16'(i * 977 - 15000), "R5");
      step(1'b0, 16'sh7fff, "R5");
      step(1'b0, -16'sd32768, "R5");
    end

    // R4: full-scale runs that push the 40-bit sum past its range
    for (int i = 0; i < 30; i++) step(1'b1, 16'sh7fff, "R4");
    for (int i = 0; i < 30; i++) step(1'b1, -16'sd32768, "R4");
    for (int i = 0; i < 30; i++) step(1'b1, (i % 2) ? 16'sh7fff : -16'sd32768, "R4");

    // R3: small negative inputs after a zero flush; floor rounding
    for (int i = 0; i < 2 * N; i++) step(1'b1, 16'sd0, "R3");
    for (int i = 0; i < 30; i++) step(1'b1, (i % 3 == 0) ? -16'sd1 : 16'sd0, "R3");

    // R2: random samples with a random strobe
    for (int i = 0; i < 2500; i++) begin
      logic v;
      v = ($urandom % 4) != 0;
      step(v, 16'($urandom), "R2");
    end

    // R7: reset in mid-stream, then random stream from a clean history
    doReset("R7");
    for (int i = 0; i < 60; i++) step(1'b1, 16'($urandom), "R7");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule